// File: doc/BRIEF.md
# Core Reconfiguration Sequencer

This controller switches an adaptive out-of-order core from one set of widths and structure sizes to another while the core is running. Three agents may ask for a new setting: a program store to a reserved address, a performance-counter bottleneck analyser, and a host over a management bus. The chosen word is checked against the legal settings. A legal word is queued in a single pending slot. An illegal word is dropped and raises a sticky error flag.

A queued request starts a fixed sequence. Fetch is stalled first. The sequencer then waits for the pipeline to report empty, and copies every architectural register into the first register-file partition through a request/acknowledge handshake. Only then does it take up the new configuration and release fetch. From the active configuration the block derives thermometer-coded enable masks, one bit per lane or partition. These masks drive clock gating and input gating of unused ports.

Top module: `reconfig_seq`

## Requirements
- R1: After reset the active configuration is the largest one (fetch 4, issue 5, four issue-queue parts, two load/store parts, two register-file steps, two reorder-buffer steps). Every enable bit is 1, and fetch_stall, copy_req and cfg_err are 0.
- R2: A configuration word packs fetch width in bits [2:0] (legal 1..4), issue width in [5:3] (legal 3..5), issue-queue parts of 16 in [8:6] (legal 1..4), load/store parts of 16 in [10:9] (legal 1..2), register-file steps of 32 above 64 in [12:11] (legal 0..2) and reorder-buffer steps of 32 above 64 in [14:13] (legal 0..2). Any other field value makes the word illegal. An illegal word starts no sequence, leaves active_cfg unchanged and sets cfg_err, which stays set until reset.
- R3: When several sources write in one cycle, the program store wins over the management bus, and the management bus wins over the analyser. Losing words are discarded.
- R4: A legal write sampled at a rising edge while idle raises fetch_stall at the second rising edge after it.
- R5: No copy request is issued before pipe_empty has been sampled high in the drain phase. fetch_stall stays high for as long as the pipeline is not empty.
- R6: Consolidation issues copy_req with copy_idx running 0, 1, … NUM_ARCH_REGS-1 in order. The index advances only on copy_ack and holds while no acknowledge arrives.
- R7: active_cfg holds its old value throughout the sequence. The new value appears in the same cycle that fetch_stall falls, two edges after the last copy_ack.
- R8: Each enable mask is a thermometer code: fetch lanes = fetch width, issue lanes = issue width, issue-queue parts = iq field, load/store parts = lsq field, and register-file and reorder-buffer parts = step field + 1 (the base partition is always on).
- R9: Legal writes that arrive during a sequence go into one pending slot, where the last one wins. That word is run when the sequencer returns to idle, without a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program store to reserved address |
| prog_cfg | input | 15 | Word from program store |
| mbus_we | input | 1 | Host management-bus write |
| mbus_cfg | input | 15 | Word from management bus |
| perf_we | input | 1 | Bottleneck-analyser write |
| perf_cfg | input | 15 | Word from analyser |
| pipe_empty | input | 1 | Pipeline fully drained |
| copy_ack | input | 1 | Current register copy done |
| fetch_stall | output | 1 | Hold instruction fetch (high during whole sequence) |
| copy_req | output | 1 | Copy request for copy_idx |
| copy_idx | output | IDX_W | Architectural register to consolidate |
| cfg_err | output | 1 | Sticky illegal-word flag |
| active_cfg | output | 15 | Configuration in force |
| fetch_lane_en | output | 4 | Fetch lane enables |
| issue_lane_en | output | 5 | Issue lane enables |
| iq_part_en | output | 4 | Issue-queue partition enables |
| lsq_part_en | output | 2 | Load/store queue partition enables |
| prf_part_en | output | 3 | Register-file partition enables |
| rob_part_en | output | 3 | Reorder-buffer partition enables |

## Verification
A corrupted sequencer state shows first on fetch_stall and copy_req. A skipped drain wait or a skipped copy shows one cycle later as an early copy_req or a missing copy_idx value. A wrong target or pending word stays hidden until the latch edge, when active_cfg and every mask change together with the fall of fetch_stall. The bench therefore compares them there against a word it tracks itself. A legality or priority fault shows within two cycles of the write, either as an unexpected stall or as a wrong cfg_err.

// File: rtl/reconfig_pkg.sv
package reconfig_pkg;

    localparam int CFG_W     = 15;
    localparam int FETCH_MAX = 4;
    localparam int ISSUE_MIN = 3;
    localparam int ISSUE_MAX = 5;
    localparam int IQ_PARTS  = 4;
    localparam int LSQ_PARTS = 2;
    localparam int EXT_STEPS = 2;
    localparam int EXT_PARTS = EXT_STEPS + 1;

    typedef struct packed {
        logic [1:0] rob;
        logic [1:0] prf;
        logic [1:0] lsq;
        logic [2:0] iq;
        logic [2:0] issue;
        logic [2:0] fetch;
    } cfg_t;

    localparam cfg_t CFG_MAX = '{
        rob:   2'(EXT_STEPS),
        prf:   2'(EXT_STEPS),
        lsq:   2'(LSQ_PARTS),
        iq:    3'(IQ_PARTS),
        issue: 3'(ISSUE_MAX),
        fetch: 3'(FETCH_MAX)
    };

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STALL  = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_CONSOL = 3'd3,
        ST_LATCH  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/cfg_check.sv
module cfg_check
    import reconfig_pkg::*;
(
    input  cfg_t cfg,
    output logic ok
);
    logic fetch_ok, issue_ok, iq_ok, lsq_ok, prf_ok, rob_ok;

    always_comb begin
        fetch_ok = (cfg.fetch >= 3'd1) && (cfg.fetch <= 3'(FETCH_MAX));
        issue_ok = (cfg.issue >= 3'(ISSUE_MIN)) && (cfg.issue <= 3'(ISSUE_MAX));
        iq_ok    = (cfg.iq >= 3'd1) && (cfg.iq <= 3'(IQ_PARTS));
        lsq_ok   = (cfg.lsq >= 2'd1) && (cfg.lsq <= 2'(LSQ_PARTS));
        prf_ok   = cfg.prf <= 2'(EXT_STEPS);
        rob_ok   = cfg.rob <= 2'(EXT_STEPS);
        ok       = fetch_ok && issue_ok && iq_ok && lsq_ok && prf_ok && rob_ok;
    end
endmodule

// File: rtl/req_arb.sv
module req_arb #(
    parameter int NSRC = 3,
    parameter int W    = 15
) (
    input  logic [NSRC-1:0]        we,
    input  logic [NSRC-1:0][W-1:0] words,
    output logic                   vld,
    output logic [W-1:0]           word
);
    // index 0 has the highest priority
    always_comb begin
        vld  = 1'b0;
        word = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (we[i]) begin
                vld  = 1'b1;
                word = words[i];
            end
        end
    end
endmodule

// File: rtl/therm_mask.sv
module therm_mask #(
    parameter int W  = 4,
    parameter int CW = 3
) (
    input  logic [CW-1:0] count,
    output logic [W-1:0]  mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (count > CW'(i));
    end
endmodule

// File: rtl/reconfig_seq.sv
module reconfig_seq
    import reconfig_pkg::*;
#(
    parameter int NUM_ARCH_REGS = 32,
    localparam int IDX_W = (NUM_ARCH_REGS > 1) ? $clog2(NUM_ARCH_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_we,
    input  logic [CFG_W-1:0]     prog_cfg,
    input  logic                 mbus_we,
    input  logic [CFG_W-1:0]     mbus_cfg,
    input  logic                 perf_we,
    input  logic [CFG_W-1:0]     perf_cfg,
    input  logic                 pipe_empty,
    input  logic                 copy_ack,
    output logic                 fetch_stall,
    output logic                 copy_req,
    output logic [IDX_W-1:0]     copy_idx,
    output logic                 cfg_err,
    output logic [CFG_W-1:0]     active_cfg,
    output logic [FETCH_MAX-1:0] fetch_lane_en,
    output logic [ISSUE_MAX-1:0] issue_lane_en,
    output logic [IQ_PARTS-1:0]  iq_part_en,
    output logic [LSQ_PARTS-1:0] lsq_part_en,
    output logic [EXT_PARTS-1:0] prf_part_en,
    output logic [EXT_PARTS-1:0] rob_part_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ARCH_REGS - 1);

    typedef struct packed {
        seq_state_e       st;
        cfg_t             active;
        cfg_t             target;
        cfg_t             pend;
        logic             pend_vld;
        logic             err;
        logic [IDX_W-1:0] idx;
    } regs_t;

    regs_t r_d, r_q;

    logic       req_vld;
    logic       req_ok;
    logic [CFG_W-1:0] req_word;

    req_arb #(.NSRC(3), .W(CFG_W)) u_arb (
        .we    ({perf_we, mbus_we, prog_we}),
        .words ({perf_cfg, mbus_cfg, prog_cfg}),
        .vld   (req_vld),
        .word  (req_word)
    );

    cfg_check u_check (
        .cfg (cfg_t'(req_word)),
        .ok  (req_ok)
    );

    always_comb begin
        r_d = r_q;
        if (req_vld) begin
            if (req_ok) begin
                r_d.pend     = cfg_t'(req_word);
                r_d.pend_vld = 1'b1;
            end else begin
                r_d.err = 1'b1;
            end
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.pend_vld) begin
                    r_d.target = r_q.pend;
                    r_d.st     = ST_STALL;
                    if (!(req_vld && req_ok)) begin
                        r_d.pend_vld = 1'b0;
                    end
                end
            end
            ST_STALL: r_d.st = ST_DRAIN;
            ST_DRAIN: begin
                if (pipe_empty) begin
                    r_d.st  = ST_CONSOL;
                    r_d.idx = '0;
                end
            end
            ST_CONSOL: begin
                if (copy_ack) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_LATCH;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_LATCH: begin
                r_d.active = r_q.target;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.active   <= CFG_MAX;
            r_q.target   <= CFG_MAX;
            r_q.pend     <= CFG_MAX;
            r_q.pend_vld <= 1'b0;
            r_q.err      <= 1'b0;
            r_q.idx      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_stall = (r_q.st != ST_IDLE);
    assign copy_req    = (r_q.st == ST_CONSOL);
    assign copy_idx    = r_q.idx;
    assign cfg_err     = r_q.err;
    assign active_cfg  = r_q.active;

    therm_mask #(.W(FETCH_MAX), .CW(3)) u_fetch_mask (
        .count (r_q.active.fetch), .mask (fetch_lane_en));
    therm_mask #(.W(ISSUE_MAX), .CW(3)) u_issue_mask (
        .count (r_q.active.issue), .mask (issue_lane_en));
    therm_mask #(.W(IQ_PARTS), .CW(3)) u_iq_mask (
        .count (r_q.active.iq), .mask (iq_part_en));
    therm_mask #(.W(LSQ_PARTS), .CW(2)) u_lsq_mask (
        .count (r_q.active.lsq), .mask (lsq_part_en));
    therm_mask #(.W(EXT_PARTS), .CW(3)) u_prf_mask (
        .count ({1'b0, r_q.active.prf} + 3'd1), .mask (prf_part_en));
    therm_mask #(.W(EXT_PARTS), .CW(3)) u_rob_mask (
        .count ({1'b0, r_q.active.rob} + 3'd1), .mask (rob_part_en));

endmodule

// File: rtl/reconfig_seq_chk.sv
module reconfig_seq_chk
    import reconfig_pkg::*;
#(
    parameter int NUM_ARCH_REGS = 32,
    localparam int IDX_W = (NUM_ARCH_REGS > 1) ? $clog2(NUM_ARCH_REGS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_stall,
    input logic                 copy_req,
    input logic                 copy_ack,
    input logic [IDX_W-1:0]     copy_idx,
    input logic                 cfg_err,
    input logic [CFG_W-1:0]     active_cfg,
    input logic [FETCH_MAX-1:0] fetch_lane_en,
    input logic [IQ_PARTS-1:0]  iq_part_en,
    input logic [EXT_PARTS-1:0] prf_part_en
);
    // R6: index holds until acknowledged
    a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !copy_ack) |=> (copy_req && copy_idx == $past(copy_idx)));

    // R5: copies only happen with fetch held
    a_r5_copy_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> fetch_stall);

    // R7: configuration changes only when fetch is released
    a_r7_cfg_on_unstall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_cfg) |-> $fell(fetch_stall));

    // R2: error flag is sticky
    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R8: masks are thermometer codes with the base bit set
    a_r8_fetch_therm: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_lane_en[0] && (((fetch_lane_en + 1'b1) & fetch_lane_en) == '0));
    a_r8_iq_therm: assert property (@(posedge clk) disable iff (!rst_n)
        iq_part_en[0] && (((iq_part_en + 1'b1) & iq_part_en) == '0));
    a_r8_prf_therm: assert property (@(posedge clk) disable iff (!rst_n)
        prf_part_en[0] && (((prf_part_en + 1'b1) & prf_part_en) == '0));
endmodule

bind reconfig_seq reconfig_seq_chk #(.NUM_ARCH_REGS(NUM_ARCH_REGS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_stall   (fetch_stall),
    .copy_req      (copy_req),
    .copy_ack      (copy_ack),
    .copy_idx      (copy_idx),
    .cfg_err       (cfg_err),
    .active_cfg    (active_cfg),
    .fetch_lane_en (fetch_lane_en),
    .iq_part_en    (iq_part_en),
    .prf_part_en   (prf_part_en)
);

// File: tb/reconfig_seq_tb.sv
`timescale 1ns/1ps
module reconfig_seq_tb;
    localparam int NREGS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0, mbus_we = 1'b0, perf_we = 1'b0;
    logic [14:0] prog_cfg = '0, mbus_cfg = '0, perf_cfg = '0;
    logic        pipe_empty = 1'b0, copy_ack = 1'b0;
    logic        fetch_stall, copy_req, cfg_err;
    logic [4:0]  copy_idx;
    logic [14:0] active_cfg;
    logic [3:0]  fetch_lane_en, iq_part_en;
    logic [4:0]  issue_lane_en;
    logic [1:0]  lsq_part_en;
    logic [2:0]  prf_part_en, rob_part_en;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    reconfig_seq #(.NUM_ARCH_REGS(NREGS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_cfg(prog_cfg),
        .mbus_we(mbus_we), .mbus_cfg(mbus_cfg),
        .perf_we(perf_we), .perf_cfg(perf_cfg),
        .pipe_empty(pipe_empty), .copy_ack(copy_ack),
        .fetch_stall(fetch_stall), .copy_req(copy_req), .copy_idx(copy_idx),
        .cfg_err(cfg_err), .active_cfg(active_cfg),
        .fetch_lane_en(fetch_lane_en), .issue_lane_en(issue_lane_en),
        .iq_part_en(iq_part_en), .lsq_part_en(lsq_part_en),
        .prf_part_en(prf_part_en), .rob_part_en(rob_part_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [14:0] mk(int rob, int prf, int lsq, int iq, int iss, int fe);
        return {2'(rob), 2'(prf), 2'(lsq), 3'(iq), 3'(iss), 3'(fe)};
    endfunction

    function automatic logic [7:0] therm(int n);
        return 8'((1 << n) - 1);
    endfunction

    function automatic logic [14:0] rand_legal();
        return mk($urandom % 3, $urandom % 3, 1 + $urandom % 2, 1 + $urandom % 4,
                  3 + $urandom % 3, 1 + $urandom % 4);
    endfunction

    function automatic logic [14:0] rand_illegal(int k);
        logic [14:0] w = rand_legal();
        case (k % 5)
            0: w[2:0]   = (($urandom % 2) == 0) ? 3'd0 : 3'(5 + $urandom % 3);
            1: w[5:3]   = 3'($urandom % 3) == 3'd2 ? 3'd6 : 3'($urandom % 3);
            2: w[8:6]   = (($urandom % 2) == 0) ? 3'd0 : 3'd5;
            3: w[10:9]  = (($urandom % 2) == 0) ? 2'd0 : 2'd3;
            default: w[12:11] = 2'd3;
        endcase
        return w;
    endfunction

    task automatic check_masks(input logic [14:0] c, input string req);
        check(fetch_lane_en == therm(int'(c[2:0])), req, fetch_lane_en, therm(int'(c[2:0])));
        check(issue_lane_en == therm(int'(c[5:3])), req, issue_lane_en, therm(int'(c[5:3])));
        check(iq_part_en == therm(int'(c[8:6])), req, iq_part_en, therm(int'(c[8:6])));
        check(lsq_part_en == therm(int'(c[10:9])), req, lsq_part_en, therm(int'(c[10:9])));
        check(prf_part_en == therm(int'(c[12:11]) + 1), req, prf_part_en, therm(int'(c[12:11]) + 1));
        check(rob_part_en == therm(int'(c[14:13]) + 1), req, rob_part_en, therm(int'(c[14:13]) + 1));
    endtask

    task automatic clear_we();
        prog_we = 1'b0; mbus_we = 1'b0; perf_we = 1'b0;
    endtask

    // Plays drain and consolidation partner; checks R4..R8 along the way.
    task automatic run_seq(input logic [14:0] exp, input int lead, input int drain, input int gap,
                           input bit inj, input logic [14:0] w1, input logic [14:0] w2);
        logic [14:0] old;
        int idx = 0, g = 0, cyc = 0;
        bit empt = 0, order_ok = 1, idx_ok = 1, hold_ok = 1;
        old = active_cfg;
        repeat (lead) begin
            @(negedge clk);
            clear_we();
        end
        check(fetch_stall == 1'b1, "R4 stall start", fetch_stall, 1);
        while (fetch_stall && cyc < 3000) begin
            if (active_cfg != old) hold_ok = 0;
            if (copy_req) begin
                if (!empt) order_ok = 0;
                if (int'(copy_idx) != idx) idx_ok = 0;
                if (g >= gap) begin copy_ack = 1'b1; idx++; g = 0; end
                else begin copy_ack = 1'b0; g++; end
            end else begin
                copy_ack = 1'b0;
            end
            pipe_empty = (cyc >= drain);
            if (pipe_empty) empt = 1;
            clear_we();
            if (inj && cyc == 2) begin mbus_we = 1'b1; mbus_cfg = w1; end
            if (inj && cyc == 3) begin perf_we = 1'b1; perf_cfg = w2; end
            @(negedge clk);
            cyc++;
        end
        copy_ack = 1'b0; pipe_empty = 1'b0; clear_we();
        check(order_ok, "R5 copy before empty", order_ok, 1);
        check(idx_ok, "R6 copy index order", idx_ok, 1);
        check(idx == NREGS, "R6 copy count", idx, NREGS);
        check(hold_ok, "R7 active held during sequence", hold_ok, 1);
        check(active_cfg == exp, "R7 new config at unstall", active_cfg, exp);
        check_masks(exp, "R8 masks");
    endtask

    initial begin
        logic [14:0] wa, wb, wc, cur;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(active_cfg == mk(2, 2, 2, 4, 5, 4), "R1 reset config", active_cfg, mk(2, 2, 2, 4, 5, 4));
        check(!fetch_stall && !copy_req && !cfg_err, "R1 reset flags",
              {fetch_stall, copy_req, cfg_err}, 0);
        check_masks(mk(2, 2, 2, 4, 5, 4), "R1 reset masks");

        // R3 all three at once: program store wins
        wa = mk(0, 0, 1, 1, 3, 1); wb = mk(1, 1, 2, 2, 4, 2); wc = mk(2, 0, 1, 3, 5, 3);
        prog_we = 1'b1; prog_cfg = wa; mbus_we = 1'b1; mbus_cfg = wb; perf_we = 1'b1; perf_cfg = wc;
        run_seq(wa, 2, 3, 0, 0, '0, '0);
        check(active_cfg == wa, "R3 program store priority", active_cfg, wa);
        // R3 bus beats analyser
        mbus_we = 1'b1; mbus_cfg = wb; perf_we = 1'b1; perf_cfg = wc;
        run_seq(wb, 2, 0, 1, 0, '0, '0);
        check(active_cfg == wb, "R3 bus priority", active_cfg, wb);

        // R5 long drain
        perf_we = 1'b1; perf_cfg = wc;
        run_seq(wc, 2, 100, 2, 0, '0, '0);

        // R9 pending, last legal write wins
        cur = mk(1, 2, 2, 4, 4, 3);
        wa = mk(0, 1, 1, 2, 3, 2); wb = mk(2, 1, 2, 1, 5, 4);
        prog_we = 1'b1; prog_cfg = cur;
        run_seq(cur, 2, 10, 0, 1, wa, wb);
        run_seq(wb, 1, 4, 1, 0, '0, '0);
        check(active_cfg == wb, "R9 pending last wins", active_cfg, wb);

        // R2 illegal words rejected
        for (int k = 0; k < 5; k++) begin
            cur = active_cfg;
            @(negedge clk);
            mbus_we = 1'b1; mbus_cfg = rand_illegal(k);
            @(negedge clk); clear_we();
            repeat (3) begin
                @(negedge clk);
                check(!fetch_stall, "R2 illegal starts nothing", fetch_stall, 0);
            end
            check(cfg_err, "R2 error flag set", cfg_err, 1);
            check(active_cfg == cur, "R2 config unchanged", active_cfg, cur);
        end

        // random legal sequences
        for (int it = 0; it < 20; it++) begin
            int src;
            cur = rand_legal();
            src = $urandom % 3;
            if (src == 0) begin prog_we = 1'b1; prog_cfg = cur; end
            else if (src == 1) begin mbus_we = 1'b1; mbus_cfg = cur; end
            else begin perf_we = 1'b1; perf_cfg = cur; end
            run_seq(cur, 2, $urandom % 40, $urandom % 4, 0, '0, '0);
            check(cfg_err, "R2 error stays set", cfg_err, 1);
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end
endmodule